// File: doc/BRIEF.md
# Data-Strobe Character Transmitter

This block turns a stream of link characters into two serial lines, a data line and a strobe line, one bit per enabled clock cycle. Every bit period changes exactly one of the two lines, so a receiver can recover a clock by XOR-ing them. Characters carry a parity bit and a flag that tells a data character from a control character. Data characters carry one byte. Control characters carry a two-bit code for flow-control, end-of-packet, error-end-of-packet or escape.

The user offers bytes and packet terminators through a valid/ready handshake. The link controller asks for flow-control characters with a one-cycle request, and reports each flow-control character received from the far end with a one-cycle credit pulse worth eight characters. The block spends one credit for each byte or terminator it sends and holds them back at zero credit. When nothing is pending, it keeps the line alive with NULL characters (escape followed by flow-control). Dropping the enable silences the line and clears all transmit state.

Top module: `ds_char_tx`

## Requirements
- R1: While enabled, every clock cycle puts one bit on d_out, and exactly one of d_out and s_out changes value. s_out toggles exactly when the new bit equals the previous one.
- R2: A data character is 10 bits: parity, flag 0, then the byte least significant bit first. tx_kind 0 selects a data character.
- R3: A control character is 4 bits: parity, flag 1, then a 2-bit code sent LSB first. The codes are flow-control 00, end-of-packet 01, error-end 10 and escape 11. tx_kind 1 sends end-of-packet, and tx_kind 2 or 3 sends error-end.
- R4: Each parity bit makes the count of ones odd over the previous character's bits after its flag, plus the current parity and flag bits. The first character after enable counts the previous bits as zero.
- R5: When no flow-control request is pending and no user character can be sent, the block sends NULL: escape immediately followed by flow-control.
- R6: Each credit_inc pulse adds 8 credits. Each data, end-of-packet or error-end character accepted removes 1. At zero credit, tx_ready stays low.
- R7: A fct_req pulse marks one flow-control character pending. At the next character boundary it goes out ahead of any user character.
- R8: Credit saturates at 56. An increment that would pass 56 leaves credit at 56 and raises credit_err for exactly the following cycle.
- R9: tx_ready is high only in a cycle that starts a new character. A user character is taken in a cycle with tx_valid and tx_ready both high and is sent in that order.
- R10: While enable is low, d_out and s_out are 0, credit_err is 0, and credit and the pending request are cleared. Increments in that time are ignored. Reset has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter on; low silences and clears it |
| tx_valid | input | 1 | User character offered |
| tx_kind | input | 2 | 0 data, 1 end-of-packet, 2/3 error-end |
| tx_byte | input | 8 | Data byte for tx_kind 0 |
| tx_ready | output | 1 | Character boundary with credit and no pending flow-control |
| fct_req | input | 1 | Pulse: queue one flow-control character |
| credit_inc | input | 1 | Pulse: far end granted 8 credits |
| d_out | output | 1 | Data line |
| s_out | output | 1 | Strobe line |
| credit_err | output | 1 | One-cycle pulse on credit overflow |

## Verification
The bench decodes the two lines back into characters, checking line coding and parity on every bit. It then tries several patterns. Idle with a user character held at zero credit must yield only NULLs. A vector table of bytes with varied bit density plus both terminators shows that framing and code positions are right. A ninth character after eight credits tells correct blocking apart from off-by-one credit. A flow-control request raised just ahead of user data shows the priority order. A run of eight increments and a burst that drains the credit show where saturation and the error pulse land. A disable period with increments shows that the clearing works.

// File: rtl/ds_char_tx.sv
module ds_char_tx #(
  parameter int CREDIT_MAX  = 56,
  parameter int CREDIT_STEP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tx_valid,
  input  logic [1:0] tx_kind,
  input  logic [7:0] tx_byte,
  output logic       tx_ready,
  input  logic       fct_req,
  input  logic       credit_inc,
  output logic       d_out,
  output logic       s_out,
  output logic       credit_err
);
  localparam int CW = $clog2(CREDIT_MAX + CREDIT_STEP + 1);
  localparam logic [CW-1:0] MAXV  = CW'(CREDIT_MAX);
  localparam logic [CW-1:0] STEPV = CW'(CREDIT_STEP);

  logic [9:0]    sh;
  logic [3:0]    cnt;
  logic          rx;
  logic          fct_pend;
  logic [CW-1:0] credit;

  logic          load, take_fct, send, d_n, rx_n, over;
  logic [9:0]    w;
  logic [3:0]    len;
  logic [CW-1:0] base, sum;

  assign load     = enable && (cnt == 4'd0);
  assign take_fct = load && fct_pend;
  assign tx_ready = load && !fct_pend && (credit != '0);
  assign send     = tx_ready && tx_valid;

  always_comb begin
    w    = '0;
    len  = 4'd8;
    rx_n = 1'b0;
    if (take_fct) begin
      w[3:0] = {2'b00, 1'b1, rx};
      len    = 4'd4;
    end else if (send) begin
      if (tx_kind == 2'b00) begin
        w    = {tx_byte, 1'b0, ~rx};
        len  = 4'd10;
        rx_n = ^tx_byte;
      end else begin
        w[3:0] = {(tx_kind[1] ? 2'b10 : 2'b01), 1'b1, rx};
        len    = 4'd4;
        rx_n   = 1'b1;
      end
    end else begin
      w[7:0] = {2'b00, 1'b1, 1'b0, 2'b11, 1'b1, rx};
    end
  end

  assign d_n  = load ? w[0] : sh[0];
  assign base = credit - CW'(send);
  assign sum  = base + (credit_inc ? STEPV : '0);
  assign over = credit_inc && (sum > MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; rx <= 1'b0; fct_pend <= 1'b0;
      credit <= '0; d_out <= 1'b0; s_out <= 1'b0; credit_err <= 1'b0;
    end else if (!enable) begin
      sh <= '0; cnt <= '0; rx <= 1'b0; fct_pend <= 1'b0;
      credit <= '0; d_out <= 1'b0; s_out <= 1'b0; credit_err <= 1'b0;
    end else begin
      d_out      <= d_n;
      s_out      <= s_out ^ (d_n == d_out);
      fct_pend   <= (fct_pend && !take_fct) || fct_req;
      credit     <= over ? MAXV : sum;
      credit_err <= over;
      if (load) begin
        sh  <= {1'b0, w[9:1]};
        cnt <= len - 4'd1;
        rx  <= rx_n;
      end else begin
        sh  <= {1'b0, sh[9:1]};
        cnt <= cnt - 4'd1;
      end
    end
  end
endmodule

// File: rtl/ds_char_tx_chk.sv
module ds_char_tx_chk #(
  parameter int CREDIT_MAX  = 56,
  parameter int CREDIT_STEP = 8,
  localparam int CW = $clog2(CREDIT_MAX + CREDIT_STEP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          d_out,
  input logic          s_out,
  input logic          tx_ready,
  input logic          credit_inc,
  input logic          credit_err,
  input logic          fct_pend,
  input logic [CW-1:0] credit
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r1_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(enable)) |-> ($countones({d_out, s_out} ^ $past({d_out, s_out})) == 1));

  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(enable)) |-> (!d_out && !s_out && !credit_err));

  a_r6_no_send_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (credit != '0));

  a_r7_fct_first: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !fct_pend);

  a_r8_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CW'(CREDIT_MAX));

  a_r8_err_after_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && credit_err) |-> ($past(credit_inc) && credit == CW'(CREDIT_MAX)));
endmodule

bind ds_char_tx ds_char_tx_chk #(.CREDIT_MAX(CREDIT_MAX), .CREDIT_STEP(CREDIT_STEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .d_out(d_out), .s_out(s_out),
  .tx_ready(tx_ready), .credit_inc(credit_inc), .credit_err(credit_err),
  .fct_pend(fct_pend), .credit(credit)
);

// File: tb/ds_char_tx_tb_top.sv
module ds_char_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic tx_valid = 1'b0, fct_req = 1'b0, credit_inc = 1'b0;
  logic [1:0] tx_kind = 2'b00;
  logic [7:0] tx_byte = 8'h00;
  logic tx_ready, d_out, s_out, credit_err;

  always #4 clk = ~clk;

  ds_char_tx dut_i (.clk(clk), .rst_n(rst_n), .enable(enable), .tx_valid(tx_valid),
    .tx_kind(tx_kind), .tx_byte(tx_byte), .tx_ready(tx_ready), .fct_req(fct_req),
    .credit_inc(credit_inc), .d_out(d_out), .s_out(s_out), .credit_err(credit_err));

  // {kind, byte}; expected code: data byte, 256 end-of-packet, 257 error-end
  localparam logic [9:0] VEC [8] = '{10'h000, 10'h0FF, 10'h0A5, 10'h03C,
                                     10'h100, 10'h081, 10'h200, 10'h07E};

  int checks = 0, fails = 0;
  int lg [0:4095];
  int nlg = 0, nulls = 0, r1_bad = 0, par_bad = 0, esc_bad = 0;

  // line decoder: 258 flow-control, NULLs counted apart
  logic [9:0] acc;
  int nb = 0;
  logic prevx = 1'b0, esc_pend = 1'b0, prev_en = 1'b0, pd = 1'b0, ps = 1'b0;
  always @(negedge clk) begin
    if (!enable) begin
      nb = 0; prevx = 1'b0; esc_pend = 1'b0; prev_en = 1'b0;
    end else begin
      if (prev_en) begin
        if ((32'(d_out != pd) + 32'(s_out != ps)) != 1) r1_bad++;
        acc[nb] = d_out;
        nb++;
        if (nb >= 2 && nb == (acc[1] ? 4 : 10)) begin
          logic rest;
          int code;
          rest = 1'b0;
          for (int i = 2; i < nb; i++) rest ^= acc[i];
          if ((prevx ^ acc[0] ^ acc[1]) != 1'b1) par_bad++;
          prevx = rest;
          code = acc[1] ? 256 + int'({acc[3], acc[2]}) : int'(acc[9:2]);
          if (esc_pend) begin
            if (code == 256) nulls++; else esc_bad++;
            esc_pend = 1'b0;
          end else if (code == 259) esc_pend = 1'b1;
          else begin
            lg[nlg] = (code == 256) ? 258 : (code >= 257 ? code - 1 : code);
            nlg++;
          end
          nb = 0;
        end
      end
      prev_en = 1'b1;
    end
    pd = d_out; ps = s_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_inc();
    credit_inc = 1'b1; step(); credit_inc = 1'b0;
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b, output bit ok);
    ok = 1'b0; tx_kind = k; tx_byte = b; tx_valid = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_ready) begin ok = 1'b1; break; end
    end
    step(); tx_valid = 1'b0;
  endtask

  task automatic hold_blocked(input int n, output bit seen);
    seen = 1'b0; tx_valid = 1'b1;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (tx_ready) seen = 1'b1; end
    step(); tx_valid = 1'b0;
  endtask

  task automatic wait_items(input int n);
    for (int i = 0; i < 400 && nlg < n; i++) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ok, seen;
    int base, n;
    repeat (4) step();
    @(negedge clk);
    chk(!d_out && !s_out, "R10 reset lines", {d_out, s_out}, 0);
    chk(!credit_err && !tx_ready, "R10 reset err/ready", {credit_err, tx_ready}, 0);
    rst_n = 1'b1; step();
    enable = 1'b1;
    tx_kind = 2'b00; tx_byte = 8'h11;
    hold_blocked(120, seen);
    chk(!seen, "R6 zero credit blocks", seen, 0);
    chk(nlg == 0, "R5 only NULL when idle", nlg, 0);
    chk(nulls >= 10, "R5 NULL fill count", nulls, 10);

    pulse_inc();
    base = nlg;
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][9:8], VEC[i][7:0], ok);
      chk(ok, "R9 vector accepted", ok, 1);
    end
    wait_items(base + 8);
    for (int i = 0; i < 8; i++) begin
      int e;
      e = (VEC[i][9:8] == 2'd0) ? int'(VEC[i][7:0]) : 255 + int'(VEC[i][9:8]);
      chk(lg[base + i] == e, "R2 R3 decoded vector", lg[base + i], e);
    end

    tx_byte = 8'hC3; tx_kind = 2'b00;
    hold_blocked(80, seen);
    chk(!seen, "R6 ninth char blocked", seen, 0);
    pulse_inc();
    base = nlg;
    send(2'b00, 8'hC3, ok);
    chk(ok, "R6 credit restored", ok, 1);
    wait_items(base + 1);
    chk(lg[base] == 8'hC3, "R2 byte after refill", lg[base], 8'hC3);

    base = nlg;
    fct_req = 1'b1; step(); fct_req = 1'b0;
    send(2'b00, 8'h5A, ok);
    wait_items(base + 2);
    chk(lg[base] == 258, "R7 flow-control first", lg[base], 258);
    chk(lg[base + 1] == 8'h5A, "R7 data after flow-control", lg[base + 1], 8'h5A);
    repeat (60) @(negedge clk);
    chk(nlg == base + 2, "R7 single flow-control", nlg, base + 2);

    enable = 1'b0; step();
    @(negedge clk);
    chk(!d_out && !s_out, "R10 disabled lines low", {d_out, s_out}, 0);
    pulse_inc(); pulse_inc();
    enable = 1'b1;
    hold_blocked(60, seen);
    chk(!seen, "R10 credit cleared, increments ignored", seen, 0);

    for (int i = 0; i < 7; i++) begin
      pulse_inc();
      @(negedge clk);
      chk(!credit_err, "R8 no error up to 56", credit_err, 0);
      step();
    end
    pulse_inc();
    @(negedge clk);
    chk(credit_err, "R8 error on overflow", credit_err, 1);
    @(negedge clk);
    chk(!credit_err, "R8 error lasts one cycle", credit_err, 0);

    base = nlg; n = 0; tx_kind = 2'b00; tx_byte = 8'd0; tx_valid = 1'b1;
    for (int idle = 0; idle < 60; ) begin
      @(negedge clk);
      if (tx_ready) begin n++; step(); tx_byte = 8'(n); idle = 0; end
      else idle++;
    end
    tx_valid = 1'b0;
    chk(n == 56, "R8 saturated credit drained", n, 56);
    wait_items(base + 56);
    chk(lg[base + 55] == 55, "R6 R9 last burst byte in order", lg[base + 55], 55);

    chk(r1_bad == 0, "R1 one line change per bit", r1_bad, 0);
    chk(par_bad == 0, "R4 odd parity chain", par_bad, 0);
    chk(esc_bad == 0, "R5 escape only within NULL", esc_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule